// File: doc/BRIEF.md
# Address-configurable packet switch

This block takes byte-wide packets from one input and delivers each whole packet to one of four output ports. The port is picked by comparing the first byte of the packet, its destination address, with four 8-bit port addresses that are written at run time through a small write-only register interface. A packet is framed by a valid signal that stays high while its bytes arrive, one per clock. The packet runs from the destination byte through the source byte and a length byte (0 to 255 data bytes) to a single trailing check byte. That gives 4 to 259 bytes in total, and every byte is forwarded unchanged.

Each output port has its own buffer, large enough for one packet of the maximum length. While a port holds unread bytes it raises its ready signal. The consumer pulls one byte per clock by holding that port's read input high, and each byte shows up on the port's data output one clock after the read was taken. A packet whose destination matches no programmed address is dropped. If more than one port has the same address, the lowest-numbered of them wins. Packets follow one another with at least three idle clocks between them. The reset is asynchronous and active high.

Top module: `packet_switch`

## Requirements
- R1: While reset is high and straight after it, every ready output is 0, every port data output is 0x00 and all four port address entries are 0x00. A packet with destination 0x00 therefore goes to port 0.
- R2: A port address entry is written only on a clock edge where cfg_en and cfg_wr are both 1. cfg_sel (0 to 3) picks the port and cfg_addr gives the new address. When only one of the two strobes is high the table does not change.
- R3: A packet whose first byte equals exactly one port address is delivered, all of its bytes in arrival order and unchanged, on that port and on no other.
- R4: The destination is looked up once, on the packet's first byte, against the table as it stood before that clock edge. A table write during the rest of the packet does not redirect it.
- R5: A packet whose first byte matches no port address is discarded in full, and no ready output rises because of it.
- R6: When several port addresses equal the destination byte, the packet goes only to the lowest-numbered of those ports.
- R7: A port's ready is 1 exactly while that port holds unread bytes. It is 0 at the first sample after the edge that reads the last byte. A read while ready is 0 removes nothing.
- R8: When read is 1 and ready is 1 at a clock edge, the oldest unread byte drives that port's data output from that edge on. At any other edge the data output holds its value.
- R9: Each port buffers 259 bytes without loss, and packets queued on one port come out back to back in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_en | input | 1 | Configuration access enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Port whose address entry is written |
| cfg_addr | input | 8 | New address for the selected port |
| in_valid | input | 1 | High while packet bytes are presented |
| in_data | input | 8 | Packet byte |
| out_data | output | 4x8 | Per-port output byte, port n in bits [8n+7:8n] |
| out_ready | output | 4 | Per-port: unread bytes are buffered |
| out_read | input | 4 | Per-port: take the next byte |

## Verification
If the latched destination or the port select were wrong inside the block, the whole packet would land on another port or vanish. That shows at the ready outputs one clock after the first byte goes in. A broken buffer pointer or count shows up as a wrong or repeated byte on the data output one clock after the read that fetches it. It can also show as a ready that stays high, or falls early, at the first sample after the last byte is read. A stale or mis-written address table shows on the next packet's routing. Packets sent to the default address after reset, to duplicate addresses, and to addresses written with a single strobe make such a fault visible.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PORTS   = 4;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = $clog2(PORTS);
    localparam int MAX_PKT = 3 + 255 + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PORTS-1:0]  port_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_DROP = 2'd2
    } ingress_state_e;

    typedef struct packed {
        port_vec_t en;
        byte_t     data;
    } port_wr_t;

    function automatic port_vec_t lowest_hit(input port_vec_t hits);
        return hits & (~hits + port_vec_t'(1));
    endfunction

endpackage

// File: rtl/psw_addr_table.sv
module psw_addr_table
    import psw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_en,
    input  logic                   cfg_wr,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  byte_t                  cfg_addr,
    output logic [PORTS-1:0][BYTE_W-1:0] port_addr
);

    logic wr_hit;
    assign wr_hit = cfg_en && cfg_wr;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            port_addr <= '0;
        end else if (wr_hit) begin
            port_addr[cfg_sel] <= cfg_addr;
        end
    end

    // R2: a write lands in the selected entry
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_wr) |=> (port_addr[$past(cfg_sel)] == $past(cfg_addr)));

    // R2: no strobe pair, no change
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(cfg_en && cfg_wr) |=> $stable(port_addr));

endmodule

// File: rtl/psw_ingress.sv
module psw_ingress
    import psw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  byte_t                         in_data,
    input  logic [PORTS-1:0][BYTE_W-1:0]  port_addr,
    output port_wr_t                      wr
);

    ingress_state_e state;
    port_vec_t      sel;
    port_vec_t      hits;
    port_vec_t      first;

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            hits[i] = (in_data == port_addr[i]);
        end
        first = lowest_hit(hits);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        if (|hits) begin
                            sel   <= first;
                            state <= ST_FWD;
                        end else begin
                            state <= ST_DROP;
                        end
                    end
                end
                ST_FWD, ST_DROP: begin
                    if (!in_valid) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr.data = in_data;
        wr.en   = '0;
        unique case (state)
            ST_IDLE: wr.en = in_valid ? first : '0;
            ST_FWD:  wr.en = in_valid ? sel : '0;
            default: wr.en = '0;
        endcase
    end

    // R6: at most one port takes a byte
    assert_single_port_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr.en));

    // R4: the chosen port stays fixed for the rest of the packet
    assert_sel_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FWD && $past(state) == ST_FWD) |-> $stable(sel));

    // R5: an unmatched packet writes nothing
    assert_drop_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP) |-> (wr.en == '0));

endmodule

// File: rtl/psw_port_fifo.sv
module psw_port_fifo
    import psw_pkg::*;
#(
    parameter int DEPTH = MAX_PKT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  rd_req,
    output logic  ready,
    output byte_t rd_data
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    byte_t          mem [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [CW-1:0]  count;
    logic           push;
    logic           pop;

    assign ready = (count != '0);
    assign pop   = rd_req && ready;
    assign push  = wr_en && (count != CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_data <= mem[rd_ptr];
                rd_ptr  <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: the ingress never writes into a full buffer
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < CW'(DEPTH)));

    // R7: a written byte makes the port ready
    assert_ready_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ready);

    // R7: reading the only byte with no write clears ready
    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ready && count == CW'(1) && !wr_en) |=> !ready);

    // R8: output holds unless a byte was taken
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && ready) |=> $stable(rd_data));

endmodule

// File: rtl/packet_switch.sv
module packet_switch
    import psw_pkg::*;
#(
    parameter int FIFO_DEPTH = MAX_PKT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_en,
    input  logic                          cfg_wr,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [BYTE_W-1:0]             cfg_addr,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    output logic [PORTS-1:0][BYTE_W-1:0]  out_data,
    output logic [PORTS-1:0]              out_ready,
    input  logic [PORTS-1:0]              out_read
);

    logic [PORTS-1:0][BYTE_W-1:0] port_addr;
    port_wr_t                     wr;

    psw_addr_table u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .port_addr (port_addr)
    );

    psw_ingress u_ingress (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .port_addr (port_addr),
        .wr        (wr)
    );

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        psw_port_fifo #(
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr.en[g]),
            .wr_data (wr.data),
            .rd_req  (out_read[g]),
            .ready   (out_ready[g]),
            .rd_data (out_data[g])
        );
    end

endmodule

// File: tb/packet_switch_test.sv
`timescale 1ns/1ps
module packet_switch_test;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [7:0]       cfg_addr = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic [3:0][7:0]  out_data;
    logic [3:0]       out_ready;
    logic [3:0]       out_read = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] model_addr [4];
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    packet_switch uut (
        .clk (clk), .rst (rst),
        .cfg_en (cfg_en), .cfg_wr (cfg_wr), .cfg_sel (cfg_sel), .cfg_addr (cfg_addr),
        .in_valid (in_valid), .in_data (in_data),
        .out_data (out_data), .out_ready (out_ready), .out_read (out_read)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_route(input logic [7:0] da);
        for (int p = 0; p < 4; p++) begin
            if (model_addr[p] == da) return p;
        end
        return -1;
    endfunction

    task automatic cfg_write(input logic en, input logic wr, input int sel, input logic [7:0] val);
        @(negedge clk);
        cfg_en = en; cfg_wr = wr; cfg_sel = 2'(sel); cfg_addr = val;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0;
        if (en && wr) model_addr[sel] = val;
    endtask

    // sends da, sa, len, data, trailer; optional table write at byte cfg_at
    task automatic send_packet(input logic [7:0] da, input int len, input int seed,
                               input int cfg_at, input int csel, input logic [7:0] cval);
        logic [7:0] pkt [$];
        int route;
        pkt.push_back(da);
        pkt.push_back(8'(seed + 8'h5a));
        pkt.push_back(8'(len));
        for (int i = 0; i < len; i++) pkt.push_back(8'(seed * 7 + i * 13 + 1));
        pkt.push_back(8'(seed ^ 8'hc3));
        route = model_route(da);
        if (route >= 0) begin
            foreach (pkt[i]) exp_q.push_back(pkt[i]);
        end
        foreach (pkt[i]) begin
            @(negedge clk);
            in_valid = 1; in_data = pkt[i];
            cfg_en = 0; cfg_wr = 0;
            if (i == cfg_at) begin
                cfg_en = 1; cfg_wr = 1; cfg_sel = 2'(csel); cfg_addr = cval;
                model_addr[csel] = cval;
            end
        end
        @(negedge clk);
        in_valid = 0; cfg_en = 0; cfg_wr = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input int p, input string req);
        int n = exp_q.size();
        check({req, " ready before drain"}, 32'(out_ready[p]), 32'(n > 0));
        out_read[p] = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({req, " byte"}, 32'(out_data[p]), 32'(exp_q[i]));
            if (i < n - 1) check({req, " ready mid"}, 32'(out_ready[p]), 32'd1);
        end
        out_read[p] = 0;
        check("R7 ready low after last byte", 32'(out_ready), 32'd0);
        exp_q.delete();
    endtask

    task automatic t_reset;
        check("R1 ready after reset", 32'(out_ready), 32'd0);
        check("R1 data after reset", out_data, 32'd0);
        send_packet(8'h00, 2, 3, -1, 0, 0);
        check("R1 R6 zero table routes to port 0", 32'(out_ready), 32'b0001);
        drain(0, "R1");
    endtask

    task automatic t_route;
        cfg_write(1, 1, 0, 8'h11);
        cfg_write(1, 1, 1, 8'h22);
        cfg_write(1, 1, 2, 8'h33);
        cfg_write(1, 1, 3, 8'h44);
        send_packet(8'h11, 0, 10, -1, 0, 0);
        check("R3 only port 0 ready", 32'(out_ready), 32'b0001);
        drain(0, "R3 port0");
        send_packet(8'h22, 1, 11, -1, 0, 0);
        check("R3 only port 1 ready", 32'(out_ready), 32'b0010);
        drain(1, "R3 port1");
        send_packet(8'h33, 7, 12, -1, 0, 0);
        check("R2 R3 only port 2 ready", 32'(out_ready), 32'b0100);
        drain(2, "R3 port2");
        send_packet(8'h44, 3, 13, -1, 0, 0);
        check("R3 only port 3 ready", 32'(out_ready), 32'b1000);
        drain(3, "R3 port3");
    endtask

    task automatic t_half_strobe;
        cfg_write(1, 0, 3, 8'h99);
        cfg_write(0, 1, 3, 8'h99);
        send_packet(8'h99, 4, 20, -1, 0, 0);
        check("R2 single strobe leaves table", 32'(out_ready), 32'd0);
        send_packet(8'h44, 0, 21, -1, 0, 0);
        check("R2 port 3 keeps old address", 32'(out_ready), 32'b1000);
        drain(3, "R2");
    endtask

    task automatic t_unmatched;
        send_packet(8'h77, 10, 30, -1, 0, 0);
        check("R5 unmatched packet dropped", 32'(out_ready), 32'd0);
        repeat (2) @(negedge clk);
        check("R5 still nothing ready", 32'(out_ready), 32'd0);
    endtask

    task automatic t_duplicate;
        cfg_write(1, 1, 2, 8'h22);
        send_packet(8'h22, 5, 40, -1, 0, 0);
        check("R6 lowest duplicate wins", 32'(out_ready), 32'b0010);
        drain(1, "R6");
        cfg_write(1, 1, 2, 8'h33);
    endtask

    task automatic t_midcfg;
        send_packet(8'h33, 6, 50, 1, 2, 8'h66);
        check("R4 route fixed at first byte", 32'(out_ready), 32'b0100);
        drain(2, "R4");
        send_packet(8'h33, 1, 51, -1, 0, 0);
        check("R4 R2 old address now unmatched", 32'(out_ready), 32'd0);
        send_packet(8'h66, 1, 52, -1, 0, 0);
        check("R4 R2 new address takes effect", 32'(out_ready), 32'b0100);
        drain(2, "R4 new");
    endtask

    task automatic t_hold;
        logic [7:0] last2;
        logic [7:0] last0;
        last2 = out_data[2];
        out_read[2] = 1;
        repeat (3) @(negedge clk);
        out_read[2] = 0;
        check("R7 R8 read while empty keeps data", 32'(out_data[2]), 32'(last2));
        check("R7 read while empty keeps ready low", 32'(out_ready[2]), 32'd0);
        last0 = out_data[0];
        send_packet(8'h11, 2, 60, -1, 0, 0);
        repeat (4) @(negedge clk);
        check("R8 no read holds data", 32'(out_data[0]), 32'(last0));
        check("R7 ready held while unread", 32'(out_ready[0]), 32'd1);
        drain(0, "R8");
    endtask

    task automatic t_two_queued;
        send_packet(8'h22, 2, 70, -1, 0, 0);
        send_packet(8'h22, 5, 71, -1, 0, 0);
        drain(1, "R9 two packets in order");
    endtask

    task automatic t_max;
        send_packet(8'h44, 255, 80, -1, 0, 0);
        check("R9 max packet queued", 32'(out_ready), 32'b1000);
        check("R9 max packet length", 32'(exp_q.size()), 32'd259);
        drain(3, "R9 max");
    endtask

    initial begin
        for (int p = 0; p < 4; p++) model_addr[p] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 ready during reset", 32'(out_ready), 32'd0);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_route();
        t_half_strobe();
        t_unmatched();
        t_duplicate();
        t_midcfg();
        t_hold();
        t_two_queued();
        t_max();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule